// File: doc/BRIEF.md
# Decoupled Vector Instruction Dispatcher

This block is the front end of a vector ring processor. It steps a program counter through a local program memory, reads one 32-bit instruction per cycle and looks at its top two bits to decide what kind of instruction it is. Compute, memory and shuffle instructions each go into their own FIFO. Each FIFO presents its head to its own backend pipeline over a valid/ready pair, so the three streams drain independently of one another. Control instructions never reach a FIFO. They run in the front end against four small counter registers, and a loop instruction uses those registers to repeat a stretch of code without unrolling it.

Data dependences survive the independent draining through a reservation table with one bit per vector register (64 of them). An instruction is written into its FIFO only when none of the three registers it names (destination and two sources) is reserved. Writing it in reserves all three. A backend returns its completion as a pulse that echoes the three register fields, and that pulse releases them. A halt instruction stops fetching. The block reports done once every FIFO is empty and no register is reserved.

The sequencer has four states. IDLE is the reset state. START moves IDLE to RUN and clears the program counter. RUN fetches and dispatches, and a halt moves it to DRAIN. DRAIN moves to DONE when everything has settled. In DONE, START moves back to RUN for a new program.

Top module: `vdisp_top`

## Requirements
- R1: After reset, and before any start pulse, no issue valid is asserted and done is low.
- R2: An instruction whose bits [31:30] are 0, 1 or 2 is delivered unchanged on issue lane 0 (compute), 1 (memory) or 2 (shuffle) respectively. Vector fields: destination [29:24], source A [23:18], source B [17:12].
- R3: Each lane delivers its instructions in program order. A head that is held (valid high, ready low) keeps its instruction word stable.
- R4: A lane whose ready is held low never holds back issue on the other two lanes for instructions that were already fetched ahead of it.
- R5: When the target FIFO (depth Q_DEPTH) is full, fetch stalls on that instruction, and later instructions are not dispatched until space frees. No instruction is lost.
- R6: An instruction that names a register reserved by a dispatched, uncompleted instruction is not dispatched until a completion releases that register.
- R7: A completion pulse on a lane, carrying bits [29:12] of the completed instruction, releases its three registers. Completions on several lanes in the same cycle are all honoured.
- R8: Control instructions have bits [31:30]=3. The opcode in [29:28] is 0 SET (counter[25:24] = imm[15:0]), 1 LOOP, 2 HALT, or 3 NOP. LOOP replaces the counter with max(counter-1,0) and jumps to address imm while the new value is nonzero; otherwise it falls through. A body closed by LOOP after SET n therefore runs n times.
- R9: HALT stops fetch. done rises only once all FIFOs are empty and no register is reserved, stays high until the next start, and drops after that start.
- R10: Control instructions (SET, LOOP, HALT, NOP) never appear on any issue lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (from IDLE or DONE) |
| pm_we | input | 1 | Program memory write enable |
| pm_waddr | input | PCW | Program memory write address |
| pm_wdata | input | 32 | Program memory write data |
| iss_valid | output | 3 | Per-lane head valid (0 compute, 1 memory, 2 shuffle) |
| iss_ready | input | 3 | Per-lane backend ready |
| iss_instr | output | 96 | Per-lane head instruction, lane q at [32q+31:32q] |
| cpl_valid | input | 3 | Per-lane completion pulse |
| cpl_regs | input | 54 | Per-lane completed register fields, lane q at [18q+17:18q] |
| done | output | 1 | Program halted and fully drained |

## Verification
Two functions can fall in the same cycle here. Completions can arrive on two lanes at once, each releasing its own registers, while fetch is held on a shuffle instruction that depends on both. The bench sets this up by withholding automatic completion, letting a compute and a memory instruction issue, and then pulsing both completion lanes on one edge. It judges the result by whether the dependent shuffle appears on its lane only after that edge, and by whether done stays low until the shuffle itself completes.

// File: rtl/vdisp_pkg.sv
`timescale 1ns/1ps
package vdisp_pkg;
    localparam int IW    = 32;          // instruction width
    localparam int RW    = 6;           // vector register index width
    localparam int NVREG = 1 << RW;     // vector registers tracked
    localparam int RGW   = 3 * RW;      // dst + two sources
    localparam int NQ    = 3;           // compute, memory, shuffle
    localparam int CIW   = 2;           // control register index width
    localparam int NCREG = 1 << CIW;

    typedef enum logic [1:0] {CAT_CMP, CAT_MEM, CAT_SHF, CAT_CTL} cat_e;
    typedef enum logic [1:0] {COP_SET, COP_LOOP, COP_HALT, COP_NOP} cop_e;
    typedef enum logic [1:0] {FS_IDLE, FS_RUN, FS_DRAIN, FS_DONE} fstate_e;
endpackage

// File: rtl/vdisp_pmem.sv
`timescale 1ns/1ps
module vdisp_pmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/vdisp_fifo.sv
`timescale 1ns/1ps
module vdisp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    output logic         empty,
    input  logic         ready,
    output logic [W-1:0] dout
);
    logic [W-1:0]    slots [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] cnt;
    logic            pop;

    assign full  = (cnt == CNTW'(DEPTH));
    assign empty = (cnt == '0);
    assign pop   = !empty && ready;
    assign dout  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R3
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !ready) |=> (!empty && $stable(dout)));
endmodule

// File: rtl/vdisp_scoreboard.sv
`timescale 1ns/1ps
module vdisp_scoreboard
    import vdisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RGW-1:0]    qry_regs,
    output logic              hazard,
    input  logic              disp_valid,
    input  logic [NQ-1:0]     cpl_valid,
    input  logic [NQ*RGW-1:0] cpl_regs,
    output logic              idle
);
    logic [NVREG-1:0] busy_q;
    logic [NVREG-1:0] set_mask, clr_mask;

    function automatic logic [NVREG-1:0] regmask(input logic [RGW-1:0] r);
        logic [NVREG-1:0] m;
        m = '0;
        m[r[3*RW-1 -: RW]] = 1'b1;
        m[r[2*RW-1 -: RW]] = 1'b1;
        m[r[RW-1:0]]       = 1'b1;
        return m;
    endfunction

    assign set_mask = disp_valid ? regmask(qry_regs) : '0;
    assign hazard   = |(busy_q & regmask(qry_regs));
    assign idle     = (busy_q == '0);

    always_comb begin
        clr_mask = '0;
        for (int q = 0; q < NQ; q++) begin
            if (cpl_valid[q]) clr_mask = clr_mask | regmask(cpl_regs[q*RGW +: RGW]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q & ~clr_mask) | set_mask;
    end

    // R6
    no_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ((busy_q & regmask(qry_regs)) == '0));

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_cpl_chk
            // R7
            release_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cpl_valid[g] |=> !busy_q[$past(cpl_regs[g*RGW + 2*RW +: RW])]);
        end
    endgenerate
endmodule

// File: rtl/vdisp_fetch.sv
`timescale 1ns/1ps
module vdisp_fetch
    import vdisp_pkg::*;
#(
    parameter int PCW   = 6,
    parameter int CRF_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [IW-1:0]  instr,
    output logic [PCW-1:0] pc,
    input  logic [NQ-1:0]  q_full,
    input  logic           q_empty_all,
    input  logic           hazard,
    input  logic           sb_idle,
    output logic [NQ-1:0]  push,
    output logic           disp_valid,
    output logic           done
);
    fstate_e          state_q, state_d;
    logic [PCW-1:0]   pc_q, pc_d;
    logic [CRF_W-1:0] crf_q [NCREG];
    logic             crf_we;
    logic [CRF_W-1:0] crf_wval;

    cat_e             cat;
    cop_e             cop;
    logic [1:0]       qi;
    logic [CIW-1:0]   cidx;
    logic [CRF_W-1:0] dec_val;
    logic [PCW-1:0]   tgt;

    assign cat     = cat_e'(instr[31:30]);
    assign qi      = instr[31:30];
    assign cop     = cop_e'(instr[29:28]);
    assign cidx    = instr[24 +: CIW];
    assign tgt     = instr[PCW-1:0];
    assign dec_val = (crf_q[cidx] == '0) ? '0 : crf_q[cidx] - CRF_W'(1);
    assign pc      = pc_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (start) state_d = FS_RUN;
            FS_RUN:   if (cat == CAT_CTL && cop == COP_HALT) state_d = FS_DRAIN;
            FS_DRAIN: if (q_empty_all && sb_idle) state_d = FS_DONE;
            FS_DONE:  if (start) state_d = FS_RUN;
            default:  state_d = FS_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        pc_d       = pc_q;
        push       = '0;
        disp_valid = 1'b0;
        crf_we     = 1'b0;
        crf_wval   = '0;
        done       = 1'b0;
        unique case (state_q)
            FS_IDLE: if (start) pc_d = '0;
            FS_RUN: begin
                if (cat != CAT_CTL) begin
                    if (!q_full[qi] && !hazard) begin
                        push[qi]   = 1'b1;
                        disp_valid = 1'b1;
                        pc_d       = pc_q + 1'b1;
                    end
                end else begin
                    unique case (cop)
                        COP_SET: begin
                            crf_we   = 1'b1;
                            crf_wval = instr[CRF_W-1:0];
                            pc_d     = pc_q + 1'b1;
                        end
                        COP_LOOP: begin
                            crf_we   = 1'b1;
                            crf_wval = dec_val;
                            pc_d     = (dec_val != '0) ? tgt : pc_q + 1'b1;
                        end
                        COP_HALT: pc_d = pc_q;
                        COP_NOP:  pc_d = pc_q + 1'b1;
                        default:  pc_d = pc_q;
                    endcase
                end
            end
            FS_DRAIN: pc_d = pc_q;
            FS_DONE: begin
                done = 1'b1;
                if (start) pc_d = '0;
            end
            default: pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            for (int i = 0; i < NCREG; i++) crf_q[i] <= '0;
        end else begin
            pc_q <= pc_d;
            if (crf_we) crf_q[cidx] <= crf_wval;
        end
    end

    // R9
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (q_empty_all && sb_idle));

    // R8
    loop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_RUN && cat == CAT_CTL && cop == COP_LOOP && crf_q[cidx] != '0)
        |=> (crf_q[$past(cidx)] == $past(crf_q[cidx]) - CRF_W'(1)));
endmodule

// File: rtl/vdisp_top.sv
`timescale 1ns/1ps
module vdisp_top
    import vdisp_pkg::*;
#(
    parameter int PM_DEPTH = 64,
    parameter int Q_DEPTH  = 4,
    parameter int CRF_W    = 16,
    localparam int PCW     = $clog2(PM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pm_we,
    input  logic [PCW-1:0]    pm_waddr,
    input  logic [IW-1:0]     pm_wdata,
    output logic [NQ-1:0]     iss_valid,
    input  logic [NQ-1:0]     iss_ready,
    output logic [NQ*IW-1:0]  iss_instr,
    input  logic [NQ-1:0]     cpl_valid,
    input  logic [NQ*RGW-1:0] cpl_regs,
    output logic              done
);
    logic [PCW-1:0] pc;
    logic [IW-1:0]  pm_rd;
    logic [NQ-1:0]  push, q_full, q_empty;
    logic           hazard, sb_idle, disp_valid;

    vdisp_pmem #(.W(IW), .DEPTH(PM_DEPTH)) u_pmem (
        .clk   (clk),
        .we    (pm_we),
        .waddr (pm_waddr),
        .wdata (pm_wdata),
        .raddr (pc),
        .rdata (pm_rd)
    );

    vdisp_fetch #(.PCW(PCW), .CRF_W(CRF_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .instr       (pm_rd),
        .pc          (pc),
        .q_full      (q_full),
        .q_empty_all (&q_empty),
        .hazard      (hazard),
        .sb_idle     (sb_idle),
        .push        (push),
        .disp_valid  (disp_valid),
        .done        (done)
    );

    vdisp_scoreboard u_sb (
        .clk        (clk),
        .rst_n      (rst_n),
        .qry_regs   (pm_rd[29:12]),
        .hazard     (hazard),
        .disp_valid (disp_valid),
        .cpl_valid  (cpl_valid),
        .cpl_regs   (cpl_regs),
        .idle       (sb_idle)
    );

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_lane
            vdisp_fifo #(.W(IW), .DEPTH(Q_DEPTH)) u_q (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (push[g]),
                .din   (pm_rd),
                .full  (q_full[g]),
                .empty (q_empty[g]),
                .ready (iss_ready[g]),
                .dout  (iss_instr[g*IW +: IW])
            );
            assign iss_valid[g] = !q_empty[g];

            // R2
            route_chk: assert property (@(posedge clk) disable iff (!rst_n)
                push[g] |-> (pm_rd[31:30] == 2'(g)));
        end
    endgenerate
endmodule

// File: tb/vdisp_top_test.sv
`timescale 1ns/1ps
module vdisp_top_test;
    logic        clk = 1'b0;
    logic        rst_n, start, pm_we, done;
    logic [5:0]  pm_waddr;
    logic [31:0] pm_wdata;
    logic [2:0]  iss_valid, iss_ready, cpl_valid;
    logic [95:0] iss_instr;
    logic [53:0] cpl_regs;

    always #10 clk = ~clk;

    vdisp_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pm_we(pm_we),
        .pm_waddr(pm_waddr), .pm_wdata(pm_wdata), .iss_valid(iss_valid),
        .iss_ready(iss_ready), .iss_instr(iss_instr), .cpl_valid(cpl_valid),
        .cpl_regs(cpl_regs), .done(done)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [31:0] lg [3][128];
    int          lc [3];
    logic [2:0]  hs, auto_c, acv, mcv;
    logic [17:0] hs_regs [3];
    logic [17:0] acr [3];
    logic [17:0] mcr [3];

    initial begin
        for (int q = 0; q < 3; q++) begin
            lc[q] = 0; hs_regs[q] = '0; acr[q] = '0; mcr[q] = '0;
        end
        hs = '0; acv = '0; mcv = '0; auto_c = 3'b111;
    end

    // handshake monitor, away from the active edge
    always @(negedge clk) begin
        for (int q = 0; q < 3; q++) begin
            if (rst_n === 1'b1 && iss_valid[q] && iss_ready[q]) begin
                lg[q][lc[q] % 128] = iss_instr[q*32 +: 32];
                lc[q] = lc[q] + 1;
                hs[q] = 1'b1;
                hs_regs[q] = iss_instr[q*32 + 12 +: 18];
            end else begin
                hs[q] = 1'b0;
            end
        end
    end

    // backend model: completion one cycle after acceptance
    always @(posedge clk) begin
        #2;
        for (int q = 0; q < 3; q++) begin
            acv[q] = auto_c[q] && hs[q];
            acr[q] = hs_regs[q];
        end
    end

    always_comb begin
        for (int q = 0; q < 3; q++) begin
            cpl_valid[q] = acv[q] | mcv[q];
            cpl_regs[q*18 +: 18] = acv[q] ? acr[q] : mcr[q];
        end
    end

    function automatic logic [31:0] vi(input logic [1:0] c, input int d, input int a, input int b);
        return {c, 6'(d), 6'(a), 6'(b), 12'h000};
    endfunction

    function automatic logic [31:0] ci(input logic [1:0] op, input int idx, input int imm);
        return {2'b11, op, 2'b00, 2'(idx), 8'h00, 16'(imm)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pm_write(input int addr, input logic [31:0] w);
        @(posedge clk); #2;
        pm_we = 1'b1; pm_waddr = 6'(addr); pm_wdata = w;
        @(posedge clk); #2;
        pm_we = 1'b0;
    endtask

    task automatic go();
        @(posedge clk); #2;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        chk(done == 1'b0, "R9 done drops after start", 32'(done), 32'd0);
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (done !== 1'b1 && n < 400) begin
            @(negedge clk); n++;
        end
        cyc(1);
        chk(done == 1'b1, "R9 done after drain", 32'(done), 32'd1);
    endtask

    task automatic pulse_cpl(input logic [2:0] m, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        @(posedge clk); #2;
        mcv = m; mcr[0] = w0[29:12]; mcr[1] = w1[29:12]; mcr[2] = w2[29:12];
        @(posedge clk); #2;
        mcv = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; pm_we = 1'b0; pm_waddr = '0; pm_wdata = '0;
        iss_ready = 3'b111;
        cyc(3);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(iss_valid == 3'b000, "R1 no issue after reset", 32'(iss_valid), 32'd0);
        end
        chk(done == 1'b0, "R1 done low after reset", 32'(done), 32'd0);
    endtask

    task automatic t_route();
        logic [31:0] c1, m1, s1, c2;
        int b0, b1, b2;
        c1 = vi(2'd0, 1, 2, 3); m1 = vi(2'd1, 4, 5, 6);
        s1 = vi(2'd2, 7, 8, 9); c2 = vi(2'd0, 10, 11, 12);
        pm_write(0, c1); pm_write(1, m1); pm_write(2, s1);
        pm_write(3, ci(2'd3, 0, 0)); pm_write(4, c2); pm_write(5, ci(2'd2, 0, 0));
        b0 = lc[0]; b1 = lc[1]; b2 = lc[2];
        iss_ready = 3'b111; auto_c = 3'b111;
        go();
        wait_done();
        chk(lc[0] - b0 == 2, "R2 compute lane count", 32'(lc[0] - b0), 32'd2);
        chk(lc[1] - b1 == 1, "R2 memory lane count", 32'(lc[1] - b1), 32'd1);
        chk(lc[2] - b2 == 1, "R10 no control on shuffle lane", 32'(lc[2] - b2), 32'd1);
        chk(lg[0][b0] == c1, "R2 compute word 0", lg[0][b0], c1);
        chk(lg[0][b0+1] == c2, "R3 compute order", lg[0][b0+1], c2);
        chk(lg[1][b1] == m1, "R2 memory word", lg[1][b1], m1);
        chk(lg[2][b2] == s1, "R2 shuffle word", lg[2][b2], s1);
        cyc(5);
        chk(done == 1'b1, "R9 done stays high", 32'(done), 32'd1);
    endtask

    task automatic t_loop();
        logic [31:0] a, b;
        int b0, b1;
        a = vi(2'd0, 20, 21, 22); b = vi(2'd1, 23, 24, 25);
        pm_write(0, ci(2'd0, 0, 3)); pm_write(1, a); pm_write(2, ci(2'd1, 0, 1));
        pm_write(3, ci(2'd0, 1, 1)); pm_write(4, b); pm_write(5, ci(2'd1, 1, 4));
        pm_write(6, ci(2'd2, 0, 0));
        b0 = lc[0]; b1 = lc[1];
        go();
        wait_done();
        chk(lc[0] - b0 == 3, "R8 loop of three", 32'(lc[0] - b0), 32'd3);
        chk(lc[1] - b1 == 1, "R8 loop of one", 32'(lc[1] - b1), 32'd1);
        chk(lg[0][b0+2] == a, "R8 repeated body word", lg[0][b0+2], a);
    endtask

    task automatic t_full();
        logic [31:0] cs [6];
        logic [31:0] m;
        int b0, b1;
        for (int i = 0; i < 6; i++) begin
            cs[i] = vi(2'd0, 30 + 3*i, 31 + 3*i, 32 + 3*i);
            pm_write(i, cs[i]);
        end
        m = vi(2'd1, 50, 51, 52);
        pm_write(6, m); pm_write(7, ci(2'd2, 0, 0));
        b0 = lc[0]; b1 = lc[1];
        iss_ready = 3'b110;
        go();
        cyc(20);
        @(negedge clk);
        chk(iss_valid[0] == 1'b1, "R5 full lane holds head", 32'(iss_valid[0]), 32'd1);
        chk(iss_valid[1] == 1'b0, "R5 fetch stalled behind full queue", 32'(iss_valid[1]), 32'd0);
        chk(lc[1] - b1 == 0, "R5 later instruction not dispatched", 32'(lc[1] - b1), 32'd0);
        chk(done == 1'b0, "R9 no done while stalled", 32'(done), 32'd0);
        cyc(1);
        iss_ready = 3'b111;
        wait_done();
        chk(lc[0] - b0 == 6, "R5 no instruction lost", 32'(lc[0] - b0), 32'd6);
        for (int i = 0; i < 6; i++)
            chk(lg[0][b0+i] == cs[i], "R3 order through full queue", lg[0][b0+i], cs[i]);
        chk(lg[1][b1] == m, "R5 resumed after space", lg[1][b1], m);
    endtask

    task automatic t_indep();
        logic [31:0] c, m1, s, m2;
        int b0, b1, b2;
        c = vi(2'd0, 1, 2, 3); m1 = vi(2'd1, 4, 5, 6);
        s = vi(2'd2, 7, 8, 9); m2 = vi(2'd1, 10, 11, 12);
        pm_write(0, c); pm_write(1, m1); pm_write(2, s); pm_write(3, m2);
        pm_write(4, ci(2'd2, 0, 0));
        b0 = lc[0]; b1 = lc[1]; b2 = lc[2];
        iss_ready = 3'b110;
        go();
        cyc(15);
        @(negedge clk);
        chk(lc[1] - b1 == 2, "R4 memory lane drained past stall", 32'(lc[1] - b1), 32'd2);
        chk(lc[2] - b2 == 1, "R4 shuffle lane drained past stall", 32'(lc[2] - b2), 32'd1);
        chk(lg[1][b1+1] == m2, "R3 memory order", lg[1][b1+1], m2);
        chk(lc[0] - b0 == 0, "R4 blocked lane issued nothing", 32'(lc[0] - b0), 32'd0);
        chk(iss_instr[31:0] == c, "R3 held head stable", iss_instr[31:0], c);
        cyc(1);
        iss_ready = 3'b111;
        wait_done();
        chk(lc[0] - b0 == 1, "R4 blocked lane released", 32'(lc[0] - b0), 32'd1);
    endtask

    task automatic t_hazard();
        logic [31:0] c, m, c2, m2, s;
        int b0, b1, b2;
        c = vi(2'd0, 5, 1, 2); m = vi(2'd1, 9, 5, 6);
        pm_write(0, c); pm_write(1, m); pm_write(2, ci(2'd2, 0, 0));
        b0 = lc[0]; b1 = lc[1];
        auto_c = 3'b000; iss_ready = 3'b111;
        go();
        cyc(15);
        @(negedge clk);
        chk(lc[0] - b0 == 1, "R6 producer issued", 32'(lc[0] - b0), 32'd1);
        chk(lc[1] - b1 == 0, "R6 dependent held", 32'(lc[1] - b1), 32'd0);
        pulse_cpl(3'b001, c, 32'd0, 32'd0);
        cyc(10);
        @(negedge clk);
        chk(lc[1] - b1 == 1, "R7 completion releases dependent", 32'(lc[1] - b1), 32'd1);
        chk(done == 1'b0, "R9 done waits for reservations", 32'(done), 32'd0);
        pulse_cpl(3'b010, 32'd0, m, 32'd0);
        cyc(5);
        chk(done == 1'b1, "R9 done after last completion", 32'(done), 32'd1);

        c2 = vi(2'd0, 40, 41, 42); m2 = vi(2'd1, 43, 44, 45); s = vi(2'd2, 46, 40, 43);
        pm_write(0, c2); pm_write(1, m2); pm_write(2, s); pm_write(3, ci(2'd2, 0, 0));
        b0 = lc[0]; b1 = lc[1]; b2 = lc[2];
        go();
        cyc(15);
        @(negedge clk);
        chk(lc[0] - b0 == 1 && lc[1] - b1 == 1, "R6 both producers issued",
            32'(lc[0] - b0 + lc[1] - b1), 32'd2);
        chk(lc[2] - b2 == 0, "R6 shuffle waits on two producers", 32'(lc[2] - b2), 32'd0);
        pulse_cpl(3'b011, c2, m2, 32'd0);
        cyc(10);
        @(negedge clk);
        chk(lc[2] - b2 == 1, "R7 simultaneous completions", 32'(lc[2] - b2), 32'd1);
        chk(lg[2][b2] == s, "R7 dependent word", lg[2][b2], s);
        chk(done == 1'b0, "R9 done low with shuffle pending", 32'(done), 32'd0);
        pulse_cpl(3'b100, 32'd0, 32'd0, s);
        cyc(5);
        chk(done == 1'b1, "R9 done after shuffle completion", 32'(done), 32'd1);
        auto_c = 3'b111;
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_route();
        t_loop();
        t_full();
        t_indep();
        t_hazard();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule